// File: doc/BRIEF.md
# Interleaved Two-Phase Current-Balanced PWM Generator

This block produces two pulse-width-modulated phase signals for a multi-phase buck converter. One counter sets the switching period. The lead phase's sawtooth restarts when that counter wraps. The lag phase's sawtooth restarts half a period later, so the two phases interleave 180 degrees apart and the combined ripple runs at twice the per-phase rate.

A voltage loop outside the block supplies a shared duty command. Each phase also gets a digital current sample. The block averages the two samples and trims each phase's pulse width against that average: the phase carrying more than its share gets a shorter pulse, and the other gets a longer one. Each phase has a one-clock strobe that marks where its current should be sampled, one third of a period after its high-side pulse ends. A registered flag reports when the average current exceeds 165% of the nominal full-load value. When the enable input is low, both phases release their outputs. The output-enable pins carry that released (high-impedance) state to the pad.

Top module: `twophase_pwm`

## Requirements
- R1: A lead cycle lasts P clocks, where P is `period_in` captured at the edge that starts the cycle. A captured value below 4 is raised to 4. The lead counter runs 0..P-1, and `pwm_a` is high while the counter is below the lead duty.
- R2: The lag phase's cycle begins floor(P/2) clocks after the lead cycle begins. Its local count is the lead count minus floor(P/2), modulo P, and `pwm_b` is high while the local count is below the lag duty.
- R3: Each phase's duty is computed as duty_cmd - gain*(own sample - floor((isen_a+isen_b)/2)). The result is clamped to the range 0 to P-1.
- R4: Period, duty command, gain and current samples are captured only at a phase's cycle start. A change in the middle of a cycle leaves that cycle's pulse unchanged.
- R5: Each phase raises its strobe for exactly one clock per cycle. The strobe comes at local count (duty + floor(P/3)) mod P.
- R6: `oc_flag` is registered. It is high one clock after the inputs satisfy 20*floor((isen_a+isen_b)/2) > 33*NOM_CUR, which for a nominal of 50 means an average of 83 or more. Otherwise it is low.
- R7: After any edge where `en` is low, `pwm_oe_a`, `pwm_oe_b`, both PWM outputs and both strobes are 0; an output enable of 0 means released (high impedance). At the first edge with `en` high, a lead cycle starts at count 0. `pwm_b` stays low until the lag phase's first cycle start.
- R8: While `rst` is high, every output is 0 after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low releases both phases |
| period_in | input | CNT_W | Switching period in clocks |
| duty_cmd | input | CNT_W | Shared duty command from the voltage loop |
| isen_a | input | CUR_W | Lead-phase current sample |
| isen_b | input | CUR_W | Lag-phase current sample |
| bal_gain | input | GAIN_W | Current-balance gain |
| pwm_a | output | 1 | Lead-phase PWM |
| pwm_oe_a | output | 1 | Lead-phase output enable |
| pwm_b | output | 1 | Lag-phase PWM |
| pwm_oe_b | output | 1 | Lag-phase output enable |
| samp_a | output | 1 | Lead-phase current sample strobe |
| samp_b | output | 1 | Lag-phase current sample strobe |
| oc_flag | output | 1 | Average over-current flag |

## Verification
The assertions assume the following:
- `en` is held low across the release of reset and for at least one clock afterwards, so that the enable-rise property has a defined previous value.
- Period values are small enough that P-1 is representable in CNT_W bits.

The random stimulus keeps to both assumptions. It takes periods from 0 to 40 (values below 4 exercise the raise to 4) and leaves `en` low around reset. It also holds each input set for a random few clocks, so that changes fall mid-cycle as well as at cycle starts.

// File: rtl/twophase_pkg.sv
package twophase_pkg;

    localparam int MIN_PERIOD = 4;
    localparam int OC_NUM     = 33;
    localparam int OC_DEN     = 20;

    typedef enum logic [0:0] {
        PH_LEAD = 1'b0,
        PH_LAG  = 1'b1
    } phase_e;

    typedef struct packed {
        logic start_lead;
        logic start_lag;
        logic idle_start;
    } tb_evt_t;

    function automatic int wrap_pos(int s, int p);
        return (s >= p) ? s - p : s;
    endfunction

    function automatic bit over_limit(int avg, int nominal);
        return (avg * OC_DEN) > (nominal * OC_NUM);
    endfunction

endpackage

// File: rtl/tp_timebase.sv
module tp_timebase
    import twophase_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CNT_W-1:0] period_in,
    output logic             run,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] per_q,
    output logic [CNT_W-1:0] third_q,
    output logic [CNT_W-1:0] lcl_lag,
    output logic [CNT_W-1:0] pin_c,
    output logic [CNT_W-1:0] third_in,
    output tb_evt_t          evt
);

    localparam logic [CNT_W-1:0] PMIN = CNT_W'(MIN_PERIOD);

    logic [CNT_W-1:0] half_q;

    always_comb begin
        pin_c          = (period_in < PMIN) ? PMIN : period_in;
        third_in       = pin_c / CNT_W'(3);
        evt.start_lead = en && (!run || (cnt == per_q - 1'b1));
        evt.idle_start = en && !run;
        evt.start_lag  = en && run && ((cnt + 1'b1) == half_q);
        lcl_lag        = (cnt >= half_q) ? (cnt - half_q) : (cnt + (per_q - half_q));
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            run     <= 1'b0;
            cnt     <= '0;
            per_q   <= PMIN;
            half_q  <= PMIN >> 1;
            third_q <= PMIN / CNT_W'(3);
        end else if (evt.start_lead) begin
            run     <= 1'b1;
            cnt     <= '0;
            per_q   <= pin_c;
            half_q  <= pin_c >> 1;
            third_q <= third_in;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/tp_balance.sv
module tp_balance
    import twophase_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int CUR_W   = 8,
    parameter int GAIN_W  = 4,
    parameter int NOM_CUR = 50
) (
    input  logic [CNT_W-1:0]  duty_cmd,
    input  logic [CUR_W-1:0]  isen_lead,
    input  logic [CUR_W-1:0]  isen_lag,
    input  logic [GAIN_W-1:0] gain,
    input  logic [CNT_W-1:0]  per_lead,
    input  logic [CNT_W-1:0]  per_lag,
    output logic [CNT_W-1:0]  duty_lead,
    output logic [CNT_W-1:0]  duty_lag,
    output logic              oc_raw
);

    localparam int WW = CNT_W + CUR_W + GAIN_W + 4;

    logic [CUR_W:0]   sum;
    logic [CUR_W-1:0] avg;
    logic [CUR_W-1:0] own  [2];
    logic [CNT_W-1:0] per  [2];
    logic [CNT_W-1:0] dout [2];

    always_comb begin
        sum     = {1'b0, isen_lead} + {1'b0, isen_lag};
        avg     = sum[CUR_W:1];
        own[0]  = isen_lead;
        own[1]  = isen_lag;
        per[0]  = per_lead;
        per[1]  = per_lag;
        oc_raw  = over_limit(int'(avg), NOM_CUR);
    end

    for (genvar g = 0; g < 2; g++) begin : g_trim
        logic signed [WW-1:0] err, corr, raw, top;
        always_comb begin
            err  = signed'(WW'(own[g])) - signed'(WW'(avg));
            corr = err * signed'(WW'(gain));
            raw  = signed'(WW'(duty_cmd)) - corr;
            top  = signed'(WW'(per[g])) - signed'(WW'(1));
            if (raw < 0)
                dout[g] = '0;
            else if (raw > top)
                dout[g] = CNT_W'(top);
            else
                dout[g] = CNT_W'(raw);
        end
    end

    assign duty_lead = dout[PH_LEAD];
    assign duty_lag  = dout[PH_LAG];

endmodule

// File: rtl/tp_phase.sv
module tp_phase
    import twophase_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             cap,
    input  logic             run,
    input  logic [CNT_W-1:0] cap_duty,
    input  logic [CNT_W-1:0] cap_third,
    input  logic [CNT_W-1:0] cap_per,
    input  logic [CNT_W-1:0] lcl,
    output logic             pwm,
    output logic             samp
);

    logic [CNT_W-1:0] duty_q;
    logic [CNT_W-1:0] spos_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            duty_q <= '0;
            spos_q <= '1;
        end else if (cap) begin
            duty_q <= cap_duty;
            spos_q <= CNT_W'(wrap_pos(int'(cap_duty) + int'(cap_third), int'(cap_per)));
        end
    end

    assign pwm  = run && (lcl < duty_q);
    assign samp = run && (lcl == spos_q);

endmodule

// File: rtl/twophase_pwm.sv
module twophase_pwm
    import twophase_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int CUR_W   = 8,
    parameter int GAIN_W  = 4,
    parameter int NOM_CUR = 50
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [CNT_W-1:0]  period_in,
    input  logic [CNT_W-1:0]  duty_cmd,
    input  logic [CUR_W-1:0]  isen_a,
    input  logic [CUR_W-1:0]  isen_b,
    input  logic [GAIN_W-1:0] bal_gain,
    output logic              pwm_a,
    output logic              pwm_oe_a,
    output logic              pwm_b,
    output logic              pwm_oe_b,
    output logic              samp_a,
    output logic              samp_b,
    output logic              oc_flag
);

    logic             tb_run;
    logic [CNT_W-1:0] tb_cnt, tb_per, tb_third, tb_lcl_lag, tb_pin, tb_third_in;
    tb_evt_t          tb_evt;
    logic [CNT_W-1:0] d_lead, d_lag;
    logic             oc_raw;

    logic             ph_cap   [2];
    logic             ph_clr   [2];
    logic [CNT_W-1:0] ph_duty  [2];
    logic [CNT_W-1:0] ph_third [2];
    logic [CNT_W-1:0] ph_per   [2];
    logic [CNT_W-1:0] ph_lcl   [2];
    logic             ph_pwm   [2];
    logic             ph_samp  [2];

    tp_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .period_in(period_in),
        .run      (tb_run),
        .cnt      (tb_cnt),
        .per_q    (tb_per),
        .third_q  (tb_third),
        .lcl_lag  (tb_lcl_lag),
        .pin_c    (tb_pin),
        .third_in (tb_third_in),
        .evt      (tb_evt)
    );

    tp_balance #(
        .CNT_W(CNT_W), .CUR_W(CUR_W), .GAIN_W(GAIN_W), .NOM_CUR(NOM_CUR)
    ) u_bal (
        .duty_cmd (duty_cmd),
        .isen_lead(isen_a),
        .isen_lag (isen_b),
        .gain     (bal_gain),
        .per_lead (tb_pin),
        .per_lag  (tb_per),
        .duty_lead(d_lead),
        .duty_lag (d_lag),
        .oc_raw   (oc_raw)
    );

    always_comb begin
        ph_cap[PH_LEAD]   = tb_evt.start_lead;
        ph_clr[PH_LEAD]   = !en;
        ph_duty[PH_LEAD]  = d_lead;
        ph_third[PH_LEAD] = tb_third_in;
        ph_per[PH_LEAD]   = tb_pin;
        ph_lcl[PH_LEAD]   = tb_cnt;
        ph_cap[PH_LAG]    = tb_evt.start_lag;
        ph_clr[PH_LAG]    = !en || tb_evt.idle_start;
        ph_duty[PH_LAG]   = d_lag;
        ph_third[PH_LAG]  = tb_third;
        ph_per[PH_LAG]    = tb_per;
        ph_lcl[PH_LAG]    = tb_lcl_lag;
    end

    for (genvar g = 0; g < 2; g++) begin : g_ph
        tp_phase #(.CNT_W(CNT_W)) u_ph (
            .clk      (clk),
            .rst      (rst),
            .clr      (ph_clr[g]),
            .cap      (ph_cap[g]),
            .run      (tb_run),
            .cap_duty (ph_duty[g]),
            .cap_third(ph_third[g]),
            .cap_per  (ph_per[g]),
            .lcl      (ph_lcl[g]),
            .pwm      (ph_pwm[g]),
            .samp     (ph_samp[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) oc_flag <= 1'b0;
        else     oc_flag <= oc_raw;
    end

    assign pwm_a    = ph_pwm[PH_LEAD];
    assign pwm_b    = ph_pwm[PH_LAG];
    assign samp_a   = ph_samp[PH_LEAD];
    assign samp_b   = ph_samp[PH_LAG];
    assign pwm_oe_a = tb_run;
    assign pwm_oe_b = tb_run;

endmodule

// File: rtl/twophase_chk.sv
module twophase_chk
    import twophase_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int CUR_W   = 8,
    parameter int NOM_CUR = 50
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic [CUR_W-1:0] isen_a,
    input logic [CUR_W-1:0] isen_b,
    input logic             pwm_a,
    input logic             pwm_oe_a,
    input logic             pwm_b,
    input logic             pwm_oe_b,
    input logic             oc_flag,
    input logic             run,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] per
);

    logic over_in;
    assign over_in = over_limit((int'(isen_a) + int'(isen_b)) / 2, NOM_CUR);

    // R7: a low enable releases both phases
    p_disable_release_r7: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!pwm_oe_a && !pwm_oe_b && !pwm_a && !pwm_b));

    // R7: a driven pulse only while the pin is enabled
    p_pwm_needs_oe_r7: assert property (@(posedge clk) disable iff (rst)
        (pwm_a || pwm_b) |-> (pwm_oe_a && pwm_oe_b));

    // R7: lag phase silent right after enable
    p_enable_start_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(en) |=> (pwm_oe_a && !pwm_b));

    // R3: clamped duty leaves the last clock of each lead cycle low
    p_clamp_last_r3: assert property (@(posedge clk) disable iff (rst)
        (run && (cnt == per - 1'b1)) |-> !pwm_a);

    // R6: flag follows the averaged threshold one clock later
    p_oc_set_r6: assert property (@(posedge clk) disable iff (rst)
        over_in |=> oc_flag);

    p_oc_clear_r6: assert property (@(posedge clk) disable iff (rst)
        !over_in |=> !oc_flag);

endmodule

bind twophase_pwm twophase_chk #(
    .CNT_W(CNT_W), .CUR_W(CUR_W), .NOM_CUR(NOM_CUR)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .isen_a  (isen_a),
    .isen_b  (isen_b),
    .pwm_a   (pwm_a),
    .pwm_oe_a(pwm_oe_a),
    .pwm_b   (pwm_b),
    .pwm_oe_b(pwm_oe_b),
    .oc_flag (oc_flag),
    .run     (tb_run),
    .cnt     (tb_cnt),
    .per     (tb_per)
);

// File: tb/sim_twophase_pwm.sv
module sim_twophase_pwm;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 8, CUR_W = 8, GAIN_W = 4, NOM = 50;
    localparam int ALL1 = (1 << CNT_W) - 1;

    logic clk = 1'b0, rst = 1'b1, en = 1'b0;
    logic [CNT_W-1:0]  period_in = 8'd10, duty_cmd = 8'd4;
    logic [CUR_W-1:0]  isen_a = 8'd40, isen_b = 8'd40;
    logic [GAIN_W-1:0] bal_gain = 4'd0;
    logic pwm_a, pwm_oe_a, pwm_b, pwm_oe_b, samp_a, samp_b, oc_flag;

    int tests = 0, fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    twophase_pwm u0 (.*);

    // expected-state model built from the requirement text
    int m_run, m_cnt, m_per, m_half, m_third, m_da, m_db, m_sa, m_sb, m_oc;

    function automatic int exp_duty(int cmd, int own, int a, int b, int g, int p);
        int r;
        r = cmd - g * (own - (a + b) / 2);
        if (r < 0) r = 0;
        if (r > p - 1) r = p - 1;
        return r;
    endfunction

    always @(posedge clk) begin
        int p;
        if (rst) begin
            m_run = 0; m_cnt = 0; m_da = 0; m_db = 0; m_sa = ALL1; m_sb = ALL1; m_oc = 0;
        end else begin
            m_oc = ((int'(isen_a) + int'(isen_b)) / 2 * 20 > NOM * 33) ? 1 : 0;
            if (!en) begin
                m_run = 0; m_cnt = 0; m_da = 0; m_db = 0; m_sa = ALL1; m_sb = ALL1;
            end else if (m_run == 0 || m_cnt == m_per - 1) begin
                p = (period_in < 4) ? 4 : int'(period_in);
                if (m_run == 0) begin m_db = 0; m_sb = ALL1; end
                m_per = p; m_half = p / 2; m_third = p / 3;
                m_da = exp_duty(duty_cmd, isen_a, isen_a, isen_b, bal_gain, p);
                m_sa = (m_da + m_third) % p;
                m_run = 1; m_cnt = 0;
            end else begin
                m_cnt++;
                if (m_cnt == m_half) begin
                    m_db = exp_duty(duty_cmd, isen_b, isen_a, isen_b, bal_gain, m_per);
                    m_sb = (m_db + m_third) % m_per;
                end
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_all();
        int lb;
        lb = (m_cnt >= m_half) ? m_cnt - m_half : m_cnt + m_per - m_half;
        chk("R1 R3 R4 pwm_a", pwm_a, (m_run != 0 && m_cnt < m_da) ? 1 : 0);
        chk("R2 R3 R4 pwm_b", pwm_b, (m_run != 0 && lb < m_db) ? 1 : 0);
        chk("R7 pwm_oe_a", pwm_oe_a, m_run);
        chk("R7 pwm_oe_b", pwm_oe_b, m_run);
        chk("R5 samp_a", samp_a, (m_run != 0 && m_cnt == m_sa) ? 1 : 0);
        chk("R5 samp_b", samp_b, (m_run != 0 && lb == m_sb) ? 1 : 0);
        chk("R6 oc_flag", oc_flag, m_oc);
    endtask

    // directed edge-spacing measurements
    int want_gap_ab = -1, want_gap_aa = -1, cyc = 0, last_a = -1, last_b = 0, prev_a = 0, prev_b = 0;

    task automatic run_cycles(int n);
        repeat (n) begin
            @(negedge clk);
            cyc++;
            check_all();
            if (pwm_a && !prev_a) begin
                if (want_gap_aa > 0 && last_a >= 0) chk("R1 lead period", cyc - last_a, want_gap_aa);
                last_a = cyc;
            end
            if (pwm_b && !prev_b && want_gap_ab > 0 && last_a >= 0)
                chk("R2 lag offset", cyc - last_a, want_gap_ab);
            prev_a = pwm_a; prev_b = pwm_b; last_b = cyc;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd7331));
        // R8 reset state
        repeat (3) @(negedge clk);
        chk("R8 reset pwm_a", pwm_a, 0);
        chk("R8 reset pwm_oe_a", pwm_oe_a, 0);
        chk("R8 reset samp_b", samp_b, 0);
        chk("R8 reset oc_flag", oc_flag, 0);
        rst = 1'b0;
        run_cycles(2);

        // R2 interleave and R1 period at 10
        en = 1'b1; period_in = 8'd10; duty_cmd = 8'd4; bal_gain = 4'd0;
        want_gap_ab = 5; want_gap_aa = 10; last_a = -1;
        run_cycles(60);
        want_gap_ab = -1;

        // R1 period below minimum is raised to 4
        period_in = 8'd2; duty_cmd = 8'd1; last_a = -1; want_gap_aa = 4;
        run_cycles(30);
        want_gap_aa = -1;

        // R3 trim with clamping in both directions
        period_in = 8'd10; duty_cmd = 8'd4; isen_a = 8'd60; isen_b = 8'd40; bal_gain = 4'd2;
        run_cycles(40);
        isen_a = 8'd44; isen_b = 8'd50; bal_gain = 4'd1; duty_cmd = 8'd5;
        run_cycles(40);

        // R6 threshold: average 82 stays low, 83 sets
        isen_a = 8'd82; isen_b = 8'd82; run_cycles(3);
        chk("R6 avg 82 low", oc_flag, 0);
        isen_a = 8'd83; isen_b = 8'd83; run_cycles(2);
        chk("R6 avg 83 high", oc_flag, 1);
        isen_a = 8'd82; isen_b = 8'd84; run_cycles(2);
        chk("R6 avg of 82,84 high", oc_flag, 1);

        // R4 mid-cycle changes, R7 disable and restart
        isen_a = 8'd40; isen_b = 8'd40;
        run_cycles(3); duty_cmd = 8'd9; period_in = 8'd16; run_cycles(3);
        duty_cmd = 8'd2; run_cycles(30);
        en = 1'b0; run_cycles(4);
        chk("R7 released", pwm_oe_a + pwm_oe_b, 0);
        en = 1'b1; run_cycles(30);

        // constrained random
        for (int i = 0; i < 600; i++) begin
            if ($urandom_range(0, 40) == 0) en = ~en;
            period_in = ($urandom_range(0, 9) == 0) ? 8'($urandom_range(0, 3)) : 8'($urandom_range(4, 40));
            duty_cmd  = 8'($urandom_range(0, 45));
            isen_a    = 8'($urandom_range(30, 110));
            isen_b    = 8'($urandom_range(30, 110));
            bal_gain  = 4'($urandom_range(0, 3));
            run_cycles($urandom_range(1, 12));
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule